// File: doc/BRIEF.md
# Phase Comparator with Lock-Driven Pump Current Control

This block compares the rising edges of a divided reference signal and a divided VCO signal, both synchronous to the system clock. It drives an up pulse when the reference edge comes first and a down pulse when the VCO edge comes first. Each pulse lasts for the number of clock cycles between the two edges. A lock judge measures every error pulse against a selectable width limit. It counts consecutive reference periods whose error stays inside that limit and raises an in-lock flag once a selectable run of such periods has passed. Any error wider than the limit clears the flag on the next clock.

The in-lock flag can pick the charge-pump current by itself. While the loop is out of lock the high-current code is driven; once it is locked the low-current code is driven. Software can instead fix the choice with a manual bit. The block also drives enables for two alternative loop filters and for a third path that is used only while high current is active. A shared output pin carries either the in-lock flag or a general-purpose bit.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A reference rising edge seen while the VCO has not risen sets `pump_up` from that clock edge until the clock edge that sees the VCO rise, so its width equals the edge distance in cycles. The mirror case drives `pump_dn`. Edges in the same cycle produce no pulse, and `pump_up` and `pump_dn` are never high together.
- R2: `thr_sel` value n (0..3) allows an error pulse of up to (n+1)*THR_UNIT clock cycles (default THR_UNIT=2, i.e. 2/4/6/8 cycles, or 10/20/30/40 ns at 200 MHz). A longer pulse makes its period fail.
- R3: `dly_sel` value 1, 2 or 3 raises `in_lock` at the 4th, 6th or 8th consecutive passing reference edge. Value 0 is reserved and never raises `in_lock`. `in_lock` rises only on a clock edge that sees a reference rising edge.
- R4: Once an error pulse exceeds the limit, `in_lock` is low on the next clock edge, while the pulse is still running.
- R5: A failing period clears the count of good periods. The reference edge that closes a failing period counts as zero, so relocking with `dly_sel`=1 takes 5 further passing edges.
- R6: With `auto_en`=1, `hi_sel` is the inverse of `in_lock`.
- R7: With `auto_en`=0, `hi_sel` follows `manual_hi` whatever the lock state.
- R8: `hi_code` (4 bits, 0.5 mA per step) equals `hi_cfg` while `hi_sel`=1 and is 0 otherwise. `lo_code` (2 bits, 50 uA per step) equals `lo_cfg` while `hi_sel`=0 and is 0 otherwise.
- R9: `filt_sel`=1 enables `filt_a_en` only and `filt_sel`=0 enables `filt_b_en` only. `filt_hc_en` equals `hi_sel`.
- R10: `shared_pin` carries `in_lock` when `pin_sel`=1 and `gpo_bit` when `pin_sel`=0.
- R11: After reset, `pump_up`, `pump_dn` and `in_lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div | input | 1 | Divided reference signal |
| vco_div | input | 1 | Divided VCO signal |
| thr_sel | input | 2 | Error width limit select |
| dly_sel | input | 2 | Good-period run length select (0 reserved) |
| auto_en | input | 1 | Lock judge controls pump current |
| manual_hi | input | 1 | Manual high-current select |
| hi_cfg | input | HI_W | High-current code setting |
| lo_cfg | input | LO_W | Low-current code setting |
| filt_sel | input | 1 | Loop filter choice |
| pin_sel | input | 1 | Shared pin source select |
| gpo_bit | input | 1 | General-purpose output bit |
| pump_up | output | 1 | Pump up pulse |
| pump_dn | output | 1 | Pump down pulse |
| hi_code | output | HI_W | Active high-current code |
| lo_code | output | LO_W | Active low-current code |
| hi_sel | output | 1 | High current selected |
| filt_a_en | output | 1 | First loop filter enable |
| filt_b_en | output | 1 | Second loop filter enable |
| filt_hc_en | output | 1 | High-current filter path enable |
| in_lock | output | 1 | Lock flag |
| shared_pin | output | 1 | Shared lock/general-purpose output |

## Verification
The comparator is driven with reference-leading, VCO-leading and coincident edge pairs over a range of distances. This separates the up and down paths and checks pulse width to the cycle. Each limit setting gets distances just at and just past the limit, so an off-by-one width comparison shows up. Each run length gets one period fewer than needed and exactly the number needed, so the count boundary is pinned down. Directed sequences then insert a wide error into a locked loop to probe the drop mid-pulse and the restart of the count.

// File: rtl/pfd_lock_pkg.sv
`timescale 1ns/1ps
package pfd_lock_pkg;

    // Comparator state: previous input levels and the two pulse flags
    typedef struct packed {
        logic ref_prev;
        logic vco_prev;
        logic up;
        logic dn;
    } cmp_state_t;

    // Run length code: value 0 is reserved and never locks
    localparam logic [1:0] DLY_RESERVED = 2'd0;

endpackage

// File: rtl/pfd_compare.sv
`timescale 1ns/1ps
module pfd_compare
    import pfd_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    output logic up,
    output logic dn,
    output logic ref_rise
);
    cmp_state_t s_d, s_q;
    logic vco_rise, up_n, dn_n;

    always_comb begin
        s_d          = s_q;
        ref_rise     = ref_in & ~s_q.ref_prev;
        vco_rise     = vco_in & ~s_q.vco_prev;
        s_d.ref_prev = ref_in;
        s_d.vco_prev = vco_in;
        up_n         = s_q.up | ref_rise;
        dn_n         = s_q.dn | vco_rise;
        // both sides seen: the error is closed, return to the idle state
        if (up_n && dn_n) begin
            s_d.up = 1'b0;
            s_d.dn = 1'b0;
        end else begin
            s_d.up = up_n;
            s_d.dn = dn_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign up = s_q.up;
    assign dn = s_q.dn;
endmodule

// File: rtl/pfd_lock_judge.sv
`timescale 1ns/1ps
module pfd_lock_judge
    import pfd_lock_pkg::*;
#(
    parameter int THR_UNIT = 2,
    parameter int WID_W    = 8,
    parameter int CNT_W    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       ref_rise,
    input  logic [1:0] thr_sel,
    input  logic [1:0] dly_sel,
    output logic       in_lock,
    output logic       err_wide
);
    localparam logic [WID_W-1:0] WID_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WID_W-1:0] wid;
        logic [CNT_W-1:0] good;
        logic             bad;
        logic             lock;
    } judge_t;

    judge_t j_d, j_q;
    logic [WID_W-1:0] thr_cyc;
    logic [CNT_W-1:0] need, good_inc;
    logic             close_ok;

    always_comb begin
        thr_cyc  = WID_W'(THR_UNIT) * (WID_W'(thr_sel) + WID_W'(1));
        need     = CNT_W'({dly_sel, 1'b0}) + CNT_W'(2);
        good_inc = (j_q.good == CNT_MAX) ? j_q.good : j_q.good + CNT_W'(1);
        err_wide = active && (j_q.wid >= thr_cyc);
        close_ok = ref_rise && !j_q.bad;

        j_d     = j_q;
        j_d.wid = active ? ((j_q.wid == WID_MAX) ? j_q.wid : j_q.wid + WID_W'(1))
                         : '0;
        j_d.bad = (ref_rise ? 1'b0 : j_q.bad) | err_wide;

        if (err_wide) begin
            j_d.good = '0;
            j_d.lock = 1'b0;
        end else if (ref_rise) begin
            if (j_q.bad) begin
                j_d.good = '0;
            end else begin
                j_d.good = good_inc;
                if (dly_sel != DLY_RESERVED && good_inc >= need)
                    j_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign in_lock = j_q.lock;
endmodule

// File: rtl/pfd_pump_select.sv
`timescale 1ns/1ps
module pfd_pump_select #(
    parameter int HI_W = 4,
    parameter int LO_W = 2
) (
    input  logic            auto_en,
    input  logic            manual_hi,
    input  logic            in_lock,
    input  logic [HI_W-1:0] hi_cfg,
    input  logic [LO_W-1:0] lo_cfg,
    input  logic            filt_sel,
    input  logic            pin_sel,
    input  logic            gpo_bit,
    output logic            hi_sel,
    output logic [HI_W-1:0] hi_code,
    output logic [LO_W-1:0] lo_code,
    output logic            filt_a_en,
    output logic            filt_b_en,
    output logic            filt_hc_en,
    output logic            shared_pin
);
    always_comb begin
        hi_sel     = auto_en ? ~in_lock : manual_hi;
        hi_code    = hi_sel ? hi_cfg : '0;
        lo_code    = hi_sel ? '0 : lo_cfg;
        filt_a_en  = filt_sel;
        filt_b_en  = ~filt_sel;
        filt_hc_en = hi_sel;
        shared_pin = pin_sel ? in_lock : gpo_bit;
    end
endmodule

// File: rtl/pfd_lock_ctrl.sv
`timescale 1ns/1ps
module pfd_lock_ctrl #(
    parameter int THR_UNIT = 2,
    parameter int WID_W    = 8,
    parameter int CNT_W    = 4,
    parameter int HI_W     = 4,
    parameter int LO_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_div,
    input  logic            vco_div,
    input  logic [1:0]      thr_sel,
    input  logic [1:0]      dly_sel,
    input  logic            auto_en,
    input  logic            manual_hi,
    input  logic [HI_W-1:0] hi_cfg,
    input  logic [LO_W-1:0] lo_cfg,
    input  logic            filt_sel,
    input  logic            pin_sel,
    input  logic            gpo_bit,
    output logic            pump_up,
    output logic            pump_dn,
    output logic [HI_W-1:0] hi_code,
    output logic [LO_W-1:0] lo_code,
    output logic            hi_sel,
    output logic            filt_a_en,
    output logic            filt_b_en,
    output logic            filt_hc_en,
    output logic            in_lock,
    output logic            shared_pin
);
    logic ref_rise;
    logic err_wide;

    pfd_compare u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_div),
        .vco_in   (vco_div),
        .up       (pump_up),
        .dn       (pump_dn),
        .ref_rise (ref_rise)
    );

    pfd_lock_judge #(
        .THR_UNIT (THR_UNIT),
        .WID_W    (WID_W),
        .CNT_W    (CNT_W)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (pump_up | pump_dn),
        .ref_rise (ref_rise),
        .thr_sel  (thr_sel),
        .dly_sel  (dly_sel),
        .in_lock  (in_lock),
        .err_wide (err_wide)
    );

    pfd_pump_select #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_sel (
        .auto_en    (auto_en),
        .manual_hi  (manual_hi),
        .in_lock    (in_lock),
        .hi_cfg     (hi_cfg),
        .lo_cfg     (lo_cfg),
        .filt_sel   (filt_sel),
        .pin_sel    (pin_sel),
        .gpo_bit    (gpo_bit),
        .hi_sel     (hi_sel),
        .hi_code    (hi_code),
        .lo_code    (lo_code),
        .filt_a_en  (filt_a_en),
        .filt_b_en  (filt_b_en),
        .filt_hc_en (filt_hc_en),
        .shared_pin (shared_pin)
    );
endmodule

// File: rtl/pfd_lock_ctrl_checks.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_checks #(
    parameter int HI_W = 4,
    parameter int LO_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pump_up,
    input logic            pump_dn,
    input logic            in_lock,
    input logic            ref_rise,
    input logic            err_wide,
    input logic [1:0]      dly_sel,
    input logic            hi_sel,
    input logic [HI_W-1:0] hi_code,
    input logic [LO_W-1:0] lo_code,
    input logic            filt_a_en,
    input logic            filt_b_en
);
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    assert_lock_on_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_lock) |-> $past(ref_rise));

    assert_reserved_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == 2'd0 && !in_lock) |=> !in_lock);

    assert_wide_unlocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_wide |=> !in_lock);

    assert_code_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_sel ? (lo_code == '0) : (hi_code == '0));

    assert_filter_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({filt_a_en, filt_b_en}) == 1);
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_checks #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .in_lock   (in_lock),
    .ref_rise  (ref_rise),
    .err_wide  (err_wide),
    .dly_sel   (dly_sel),
    .hi_sel    (hi_sel),
    .hi_code   (hi_code),
    .lo_code   (lo_code),
    .filt_a_en (filt_a_en),
    .filt_b_en (filt_b_en)
);

// File: tb/pfd_lock_ctrl_tb.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_tb;
    localparam int PER = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0, vco_div = 1'b0;
    logic [1:0] thr_sel = 2'd0, dly_sel = 2'd1;
    logic auto_en = 1'b1, manual_hi = 1'b0;
    logic [3:0] hi_cfg = 4'hA;
    logic [1:0] lo_cfg = 2'h3;
    logic filt_sel = 1'b1, pin_sel = 1'b1, gpo_bit = 1'b0;
    logic pump_up, pump_dn, hi_sel, filt_a_en, filt_b_en, filt_hc_en, in_lock, shared_pin;
    logic [3:0] hi_code;
    logic [1:0] lo_code;

    int errors = 0;
    int checks = 0;
    int wup, wdn;
    logic lk_at [PER];
    logic up_at [PER];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfd_lock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
        .thr_sel(thr_sel), .dly_sel(dly_sel), .auto_en(auto_en), .manual_hi(manual_hi),
        .hi_cfg(hi_cfg), .lo_cfg(lo_cfg), .filt_sel(filt_sel), .pin_sel(pin_sel),
        .gpo_bit(gpo_bit), .pump_up(pump_up), .pump_dn(pump_dn), .hi_code(hi_code),
        .lo_code(lo_code), .hi_sel(hi_sel), .filt_a_en(filt_a_en), .filt_b_en(filt_b_en),
        .filt_hc_en(filt_hc_en), .in_lock(in_lock), .shared_pin(shared_pin)
    );

    // lead_vco, distance, thr_sel, dly_sel, periods, expected lock
    typedef struct packed {
        logic       lead_vco;
        logic [3:0] d;
        logic [1:0] thr;
        logic [1:0] dly;
        logic [3:0] nper;
        logic       exp_lock;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 4'd2, 2'd0, 2'd1, 4'd4,  1'b1},
        '{1'b0, 4'd2, 2'd0, 2'd1, 4'd3,  1'b0},
        '{1'b0, 4'd3, 2'd0, 2'd1, 4'd6,  1'b0},
        '{1'b1, 4'd4, 2'd1, 2'd2, 4'd6,  1'b1},
        '{1'b1, 4'd4, 2'd1, 2'd2, 4'd5,  1'b0},
        '{1'b0, 4'd5, 2'd1, 2'd3, 4'd8,  1'b0},
        '{1'b0, 4'd6, 2'd2, 2'd3, 4'd8,  1'b1},
        '{1'b1, 4'd8, 2'd3, 2'd3, 4'd8,  1'b1},
        '{1'b1, 4'd9, 2'd3, 2'd3, 4'd8,  1'b0},
        '{1'b0, 4'd0, 2'd0, 2'd1, 4'd4,  1'b1},
        '{1'b0, 4'd1, 2'd0, 2'd0, 4'd10, 1'b0},
        '{1'b0, 4'd7, 2'd2, 2'd1, 4'd6,  1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_div = 1'b0; vco_div = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One reference period; the leading signal rises at cycle 0,
    // the other d cycles later, both high for 4 cycles.
    task automatic run_period(input logic lead_vco, input int d);
        wup = 0; wdn = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            if (lead_vco) begin
                vco_div = (c < 4);
                ref_div = (c >= d) && (c < d + 4);
            end else begin
                ref_div = (c < 4);
                vco_div = (c >= d) && (c < d + 4);
            end
            @(posedge clk);
            #1;
            if (pump_up) wup++;
            if (pump_dn) wdn++;
            lk_at[c] = in_lock;
            up_at[c] = pump_up;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Table-driven comparator and lock tests (R1, R2, R3)
        for (int i = 0; i < 12; i++) begin
            thr_sel = VECS[i].thr;
            dly_sel = VECS[i].dly;
            do_reset();
            for (int p = 0; p < int'(VECS[i].nper); p++)
                run_period(VECS[i].lead_vco, int'(VECS[i].d));
            if (VECS[i].lead_vco) begin
                check("R1 down width", wdn, int'(VECS[i].d));
            end else begin
                check("R1 up width", wup, int'(VECS[i].d));
            end
            check("R2/R3 lock after run", int'(in_lock), int'(VECS[i].exp_lock));
        end

        // Reset state (R11, R6)
        thr_sel = 2'd0; dly_sel = 2'd1; auto_en = 1'b1;
        do_reset();
        check("R11 up after reset", int'(pump_up), 0);
        check("R11 dn after reset", int'(pump_dn), 0);
        check("R11 lock after reset", int'(in_lock), 0);
        check("R6 high current when unlocked", int'(hi_sel), 1);
        check("R8 high code active", int'(hi_code), 10);
        check("R8 low code idle", int'(lo_code), 0);

        // Manual select while unlocked (R7)
        @(negedge clk); auto_en = 1'b0; manual_hi = 1'b0; #1;
        check("R7 manual low while unlocked", int'(hi_sel), 0);
        check("R9 hc path follows select", int'(filt_hc_en), 0);
        @(negedge clk); auto_en = 1'b1;

        // Filter choice (R9)
        @(negedge clk); filt_sel = 1'b0; #1;
        check("R9 filter b enabled", int'({filt_a_en, filt_b_en}), 1);
        @(negedge clk); filt_sel = 1'b1; #1;
        check("R9 filter a enabled", int'({filt_a_en, filt_b_en}), 2);

        // Lock then observe automatic switch (R6, R8)
        for (int p = 0; p < 4; p++) run_period(1'b0, 1);
        check("R3 lock after 4 good", int'(in_lock), 1);
        check("R6 low current when locked", int'(hi_sel), 0);
        check("R8 low code active", int'(lo_code), 3);
        check("R8 high code idle", int'(hi_code), 0);

        // Shared pin (R10)
        @(negedge clk); #1;
        check("R10 pin shows lock", int'(shared_pin), 1);
        @(negedge clk); pin_sel = 1'b0; gpo_bit = 1'b0; #1;
        check("R10 pin shows gpo 0", int'(shared_pin), 0);
        @(negedge clk); gpo_bit = 1'b1; #1;
        check("R10 pin shows gpo 1", int'(shared_pin), 1);
        @(negedge clk); pin_sel = 1'b1;

        // Manual high while locked (R7)
        @(negedge clk); auto_en = 1'b0; manual_hi = 1'b1; #1;
        check("R7 manual high while locked", int'(hi_sel), 1);
        @(negedge clk); auto_en = 1'b1; manual_hi = 1'b0;

        // Wide error mid-pulse drops lock (R4)
        run_period(1'b0, 9);
        check("R4 lock held before limit", int'(lk_at[1]), 1);
        check("R4 lock dropped mid pulse", int'(lk_at[3]), 0);
        check("R4 pulse still running", int'(up_at[3]), 1);
        check("R6 back to high current", int'(hi_sel), 1);

        // Count restart after failing period (R5)
        for (int p = 0; p < 4; p++) run_period(1'b0, 1);
        check("R5 no lock 4 edges after fail", int'(in_lock), 0);
        run_period(1'b0, 1);
        check("R5 lock on 5th edge after fail", int'(in_lock), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule